// File: doc/BRIEF.md
# Module Slot Window Decoder

This block sits between the local bus of a carrier board and four plug-in module slots. A host access arrives in one of three module windows or in a small configuration window. The block works out which slot the access targets, which sub-space inside the slot it hits and which offset the slot should see. It then raises a request strobe toward that slot in the same cycle. Read data comes back from the slot in that cycle and reaches the host one clock later.

Two of the module windows can run in big-endian mode. In that mode a byte access has its lowest address bit inverted before it is decoded, and halfword data has its two bytes exchanged on the way in and on the way out. The window for byte-wide memory never adapts. Three mode bits are held in the configuration window and are set by byte writes to fixed byte offsets. The first bit belongs to the carrier's control-register window, which is decoded elsewhere, so it is only exported. Accesses to an empty slot, and accesses whose size a window does not accept, are dropped: reads of them return zero.

Top module: `slot_window_decoder`

## Requirements
- R1: After reset all three mode bits are zero (little-endian), `ctrl_big_endian` is 0 and `rsp_valid` is 0.
- R2: Register window (`req_win`=1): slot = address bits [9:8]; address bits [7:6] pick the sub-space, 2 giving ID (`mod_space`=1), 3 giving interrupt (`mod_space`=2), 0 or 1 giving I/O (`mod_space`=0); the offset is address AND 0x7F for I/O and AND 0x3F for ID and interrupt.
- R3: Halfword memory window (`req_win`=2): slot = address bits [24:23], offset = address bits [22:0], `mod_space`=3.
- R4: Byte memory window (`req_win`=3): slot = address bits [23:22], offset = address bits [21:0], `mod_space`=3, and no endian adaptation is ever applied in it.
- R5: When window 1 or 2 is in big-endian mode, a byte access (`req_size16`=0) has address bit 0 inverted before slot, sub-space and offset are decoded.
- R6: When window 1 or 2 is in big-endian mode, the two bytes of 16-bit write data toward the slot and of 16-bit read data toward the host are exchanged. In little-endian mode they pass unchanged.
- R7: Configuration window (`req_win`=0): a byte write to offset 0x2B, 0x2F or 0x33 stores `req_wdata[0]` as the mode bit of the control window, window 1 or window 2 in that order. A byte read of one of these offsets returns `CFG_FIXED` OR the stored bit in bits [7:0]. Any other offset reads zero and ignores writes. A 16-bit access there reads zero and changes nothing. Mode bit 0 is driven on `ctrl_big_endian`.
- R8: An access whose decoded slot has `slot_present` low raises no `mod_req`, and a read of it returns zero.
- R9: A 16-bit access to the byte memory window raises no `mod_req` and a read of it returns zero. Windows 1 and 2 accept both sizes.
- R10: `mod_req` is high in exactly the cycles where `req_valid` carries an accepted access, with `mod_write` equal to `req_write`. Every read is answered by `rsp_valid` one clock later with its data. Writes produce no `rsp_valid`.
- R11: A byte write passes `req_wdata[7:0]` to the slot with the upper byte zero. A byte read returns `mod_rdata[7:0]` with the upper byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | 0 config, 1 register window, 2 halfword memory, 3 byte memory |
| req_size16 | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | 25 | Byte address within the window |
| req_wdata | input | 16 | Host write data |
| slot_present | input | 4 | One bit per fitted slot |
| mod_req | output | 1 | Request strobe toward the selected slot |
| mod_write | output | 1 | Direction of the slot request |
| mod_slot | output | 2 | Selected slot |
| mod_space | output | 2 | 0 I/O, 1 ID, 2 interrupt, 3 memory |
| mod_offset | output | 23 | Masked offset inside the sub-space |
| mod_wdata | output | 16 | Lane-adapted write data toward the slot |
| mod_rdata | input | 16 | Read data from the selected slot, same cycle as `mod_req` |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Lane-adapted read data toward the host |
| ctrl_big_endian | output | 1 | Mode bit of the control-register window |

## Verification
The assertions take for granted that `req_valid` is never held high across two cycles for the same access. Each high cycle is taken as a fresh access, so the one-cycle response rule counts every read cycle. They also take for granted that `mod_rdata` is defined whenever `mod_req` rises for a read. The stimulus drives each access for exactly one cycle and leaves one idle cycle after it. It derives `mod_rdata` from the address and holds it steady through the cycle. The stimulus uses window 1 addresses only below 0x400 and config offsets only below 0x80. Above those ranges the decode of window 1 ignores the upper bits.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;
    localparam int DATA_W      = 16;
    localparam int MODE_CNT    = 3;
    localparam int MODE_CTRL   = 0;
    localparam int MODE_IOS    = 1;
    localparam int MODE_M16    = 2;
    localparam int MODE_BYTE0  = 'h2B;
    localparam int MODE_STRIDE = 4;

    typedef enum logic [1:0] {
        WIN_CFG = 2'd0,
        WIN_IOS = 2'd1,
        WIN_M16 = 2'd2,
        WIN_M8  = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        SP_IO  = 2'd0,
        SP_ID  = 2'd1,
        SP_INT = 2'd2,
        SP_MEM = 2'd3
    } space_e;

    typedef struct packed {
        logic [MODE_CNT-1:0] be;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rsp_data;
    } state_t;
endpackage

// File: rtl/swd_addr_split.sv
`timescale 1ns/1ps
module swd_addr_split
    import swd_pkg::*;
#(
    parameter int SLOT_W      = 2,
    parameter int ADDR_W      = 25,
    parameter int OFF_W       = 23,
    parameter int IO_SLOT_LSB = 8,
    parameter int M16_OFF_W   = 23,
    parameter int M8_OFF_W    = 22
) (
    input  win_e              win,
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output space_e            space,
    output logic [OFF_W-1:0]  offset
);
    localparam int IO_OFF_W  = IO_SLOT_LSB - 1;
    localparam int REG_OFF_W = IO_SLOT_LSB - 2;

    always_comb begin
        slot   = '0;
        space  = SP_IO;
        offset = '0;
        unique case (win)
            WIN_IOS: begin
                slot = addr[IO_SLOT_LSB +: SLOT_W];
                unique case (addr[IO_SLOT_LSB-1 -: 2])
                    2'd2:    space = SP_ID;
                    2'd3:    space = SP_INT;
                    default: space = SP_IO;
                endcase
                if (space == SP_IO) offset[IO_OFF_W-1:0]  = addr[IO_OFF_W-1:0];
                else                offset[REG_OFF_W-1:0] = addr[REG_OFF_W-1:0];
            end
            WIN_M16: begin
                slot = addr[M16_OFF_W +: SLOT_W];
                space = SP_MEM;
                offset[M16_OFF_W-1:0] = addr[M16_OFF_W-1:0];
            end
            WIN_M8: begin
                slot = addr[M8_OFF_W +: SLOT_W];
                space = SP_MEM;
                offset[M8_OFF_W-1:0] = addr[M8_OFF_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/swd_lane_adapt.sv
`timescale 1ns/1ps
module swd_lane_adapt #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  logic              wide,
    input  logic              swap,
    output logic [DATA_W-1:0] dout
);
    localparam int LANE_W = DATA_W / 2;

    always_comb begin
        dout = '0;
        if (!wide)     dout[LANE_W-1:0] = din[LANE_W-1:0];
        else if (swap) dout = {din[LANE_W-1:0], din[DATA_W-1:LANE_W]};
        else           dout = din;
    end
endmodule

// File: rtl/slot_window_decoder.sv
`timescale 1ns/1ps
module slot_window_decoder
    import swd_pkg::*;
#(
    parameter int         SLOTS       = 4,
    parameter int         IO_SLOT_LSB = 8,
    parameter int         M16_OFF_W   = 23,
    parameter int         M8_OFF_W    = 22,
    parameter logic [7:0] CFG_FIXED   = 8'h50,
    localparam int        SLOT_W      = $clog2(SLOTS),
    localparam int        ADDR_W      = M16_OFF_W + SLOT_W,
    localparam int        OFF_W       = M16_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_win,
    input  logic              req_size16,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [SLOTS-1:0]  slot_present,
    output logic              mod_req,
    output logic              mod_write,
    output logic [SLOT_W-1:0] mod_slot,
    output logic [1:0]        mod_space,
    output logic [OFF_W-1:0]  mod_offset,
    output logic [15:0]       mod_wdata,
    input  logic [15:0]       mod_rdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              ctrl_big_endian
);
    state_t st_d, st_q;

    win_e              win;
    logic              be_sel;
    logic [ADDR_W-1:0] addr_eff;
    space_e            space;
    logic              legal;
    logic [DATA_W-1:0] rd_adapt;
    logic              cfg_byte;
    logic [MODE_CNT-1:0] mode_hit;
    logic [DATA_W-1:0] cfg_rd;

    assign win = win_e'(req_win);

    // Window-specific endian mode; the byte memory window never adapts.
    always_comb begin
        unique case (win)
            WIN_IOS: be_sel = st_q.be[MODE_IOS];
            WIN_M16: be_sel = st_q.be[MODE_M16];
            default: be_sel = 1'b0;
        endcase
    end

    assign addr_eff = req_addr ^ ADDR_W'(be_sel && !req_size16);

    swd_addr_split #(
        .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .IO_SLOT_LSB(IO_SLOT_LSB), .M16_OFF_W(M16_OFF_W), .M8_OFF_W(M8_OFF_W)
    ) u_split (
        .win(win), .addr(addr_eff), .slot(mod_slot), .space(space), .offset(mod_offset)
    );

    assign mod_space = space;
    assign legal     = (win == WIN_IOS) || (win == WIN_M16) || (win == WIN_M8 && !req_size16);
    assign mod_req   = req_valid && legal && slot_present[mod_slot];
    assign mod_write = req_write;

    swd_lane_adapt #(.DATA_W(DATA_W)) u_wr_lane (
        .din(req_wdata), .wide(req_size16), .swap(be_sel), .dout(mod_wdata)
    );
    swd_lane_adapt #(.DATA_W(DATA_W)) u_rd_lane (
        .din(mod_rdata), .wide(req_size16), .swap(be_sel), .dout(rd_adapt)
    );

    // Mode bytes of the configuration window, one per adapted window.
    assign cfg_byte = (win == WIN_CFG) && !req_size16;
    for (genvar i = 0; i < MODE_CNT; i++) begin : g_mode
        assign mode_hit[i] = cfg_byte && (req_addr == ADDR_W'(MODE_BYTE0 + MODE_STRIDE * i));
    end

    always_comb begin
        cfg_rd = '0;
        for (int i = 0; i < MODE_CNT; i++)
            if (mode_hit[i]) cfg_rd = {8'h00, CFG_FIXED | {7'b0, st_q.be[i]}};
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid && !req_write;
        st_d.rsp_data  = '0;
        if (req_valid && !req_write)
            st_d.rsp_data = mod_req ? rd_adapt : cfg_rd;
        for (int i = 0; i < MODE_CNT; i++)
            if (req_valid && req_write && mode_hit[i]) st_d.be[i] = req_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid       = st_q.rsp_valid;
    assign rsp_rdata       = st_q.rsp_data;
    assign ctrl_big_endian = st_q.be[MODE_CTRL];

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R10
    AST_REQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mod_req |-> req_valid); // R10
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && win != WIN_CFG && !slot_present[mod_slot]) |=> rsp_rdata == '0); // R8
    AST_BYTE_WIN_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && win == WIN_M8) |-> !req_size16); // R9
    AST_MEM_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && (win == WIN_M16 || win == WIN_M8)) |-> mod_space == SP_MEM); // R3
    AST_IO_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && win == WIN_IOS) |-> (mod_space == SP_IO ? mod_offset < 128 : mod_offset < 64)); // R2
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && win == WIN_CFG) |=> $stable(st_q.be)); // R7
    AST_CFG_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (win == WIN_CFG) |-> !mod_req); // R7
endmodule

// File: tb/sim_slot_window_decoder.sv
`timescale 1ns/1ps
module sim_slot_window_decoder;
    localparam logic [7:0] CFG_FIXED = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_size16;
    logic [1:0]  req_win;
    logic [24:0] req_addr;
    logic [15:0] req_wdata, mod_rdata;
    logic [3:0]  slot_present;
    logic        mod_req, mod_write, rsp_valid, ctrl_big_endian;
    logic [1:0]  mod_slot, mod_space;
    logic [22:0] mod_offset;
    logic [15:0] mod_wdata, rsp_rdata;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    logic [2:0] mb;

    always #2.5 clk = ~clk;

    slot_window_decoder #(.CFG_FIXED(CFG_FIXED)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_win(req_win), .req_size16(req_size16), .req_addr(req_addr),
        .req_wdata(req_wdata), .slot_present(slot_present), .mod_req(mod_req),
        .mod_write(mod_write), .mod_slot(mod_slot), .mod_space(mod_space),
        .mod_offset(mod_offset), .mod_wdata(mod_wdata), .mod_rdata(mod_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ctrl_big_endian(ctrl_big_endian)
    );

    function automatic logic [15:0] sw(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input int win, input bit wr, input bit s16,
                       input logic [24:0] a, input logic [15:0] wd);
        logic        be;
        logic [24:0] ea;
        logic [1:0]  es, esp;
        logic [22:0] eo;
        bit          legal, ereq;
        logic [15:0] rd, erd, ewd;
        string       otag, dtag, qtag;
        be  = (win == 1) ? mb[1] : (win == 2) ? mb[2] : 1'b0;
        ea  = (be && !s16) ? (a ^ 25'd1) : a;
        es = 2'd0; esp = 2'd0; eo = '0;
        case (win)
            1: begin
                es = ea[9:8];
                esp = (ea[7:6] == 2'd2) ? 2'd1 : (ea[7:6] == 2'd3) ? 2'd2 : 2'd0;
                eo = (esp == 2'd0) ? {16'h0, ea[6:0]} : {17'h0, ea[5:0]};
            end
            2: begin es = ea[24:23]; esp = 2'd3; eo = ea[22:0]; end
            3: begin es = ea[23:22]; esp = 2'd3; eo = {1'b0, ea[21:0]}; end
            default: ;
        endcase
        legal = (win == 1) || (win == 2) || (win == 3 && !s16);
        ereq  = legal && slot_present[es];
        rd    = {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h5A};
        ewd   = s16 ? (be ? sw(wd) : wd) : {8'h00, wd[7:0]};
        if (win == 0) begin
            erd = 16'h0;
            for (int i = 0; i < 3; i++)
                if (!s16 && a == 25'(8'h2B + 4 * i)) erd = {8'h00, CFG_FIXED | {7'b0, mb[i]}};
        end else begin
            erd = ereq ? (s16 ? (be ? sw(rd) : rd) : {8'h00, rd[7:0]}) : 16'h0;
        end
        otag = (be && !s16) ? "R5 flipped decode" : (win == 1) ? "R2 decode" :
               (win == 2) ? "R3 decode" : "R4 decode";
        dtag = s16 ? "R6 lane data" : "R11 byte data";
        qtag = (win == 0) ? "R7 cfg no slot req" : !legal ? "R9 size drop" :
               !slot_present[es] ? "R8 empty slot" : "R10 strobe";

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_win = 2'(win); req_size16 = s16;
        req_addr = a; req_wdata = wd; mod_rdata = rd;
        #1;
        check(qtag, mod_req, ereq);
        if (ereq) begin
            check(otag, {30'h0, mod_slot}, {30'h0, es});
            check(otag, {30'h0, mod_space}, {30'h0, esp});
            check(otag, {9'h0, mod_offset}, {9'h0, eo});
            check("R10 direction", mod_write, wr);
            if (wr) check(dtag, mod_wdata, ewd);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R10 strobe drop", mod_req, 1'b0);
        check("R10 rsp valid", rsp_valid, !wr);
        if (!wr) check((win == 0) ? "R7 cfg read" : !ereq ? qtag : dtag, rsp_rdata, erd);
        if (win == 0 && wr && !s16)
            for (int i = 0; i < 3; i++)
                if (a == 25'(8'h2B + 4 * i)) mb[i] = wd[0];
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog act=%0d exp=%0d", checks, 0);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_win = 2'd0;
        req_size16 = 1'b0; req_addr = '0; req_wdata = '0; mod_rdata = '0;
        slot_present = 4'b1111; mb = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 rsp idle", rsp_valid, 1'b0);
        check("R1 ctrl mode", ctrl_big_endian, 1'b0);
        for (int i = 0; i < 3; i++) acc(0, 0, 0, 25'(8'h2B + 4 * i), 16'h0); // R1 modes read zero

        // R7: every other config byte reads zero and ignores writes; 16-bit access dropped
        for (int a = 0; a < 128; a++)
            if (a != 'h2B && a != 'h2F && a != 'h33) acc(0, 1, 0, 25'(a), 16'hFFFF);
        for (int i = 0; i < 3; i++) acc(0, 1, 1, 25'(8'h2B + 4 * i), 16'hFFFF);
        for (int a = 0; a < 128; a++) acc(0, 0, 0, 25'(a), 16'h0);
        acc(0, 0, 1, 25'h2B, 16'h0);
        check("R7 ctrl mode unchanged", ctrl_big_endian, 1'b0);

        // R7: set and clear each mode bit
        for (int i = 0; i < 3; i++) begin
            acc(0, 1, 0, 25'(8'h2B + 4 * i), 16'h0001);
            acc(0, 0, 0, 25'(8'h2B + 4 * i), 16'h0);
        end
        #1 check("R7 ctrl mode set", ctrl_big_endian, 1'b1);
        acc(0, 1, 0, 25'h2B, 16'h00FE);
        #1 check("R7 ctrl mode clear", ctrl_big_endian, 1'b0);

        // R2 R5 R6 R8 R11: sweep the register window in both modes
        slot_present = 4'b1011;
        for (int m = 0; m < 2; m++) begin
            acc(0, 1, 0, 25'h2F, 16'(m));
            acc(0, 1, 0, 25'h33, 16'(m));
            for (int a = 0; a < 1024; a++)
                for (int k = 0; k < 4; k++)
                    acc(1, k[0], k[1], 25'(a), 16'(a * 37 + 16'h1234));
        end

        // R3 R4 R5 R6 R9: memory windows, both modes, every slot
        slot_present = 4'b0111;
        for (int m = 0; m < 2; m++) begin
            acc(0, 1, 0, 25'h33, 16'(m));
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 6; o++)
                    for (int k = 0; k < 4; k++) begin
                        logic [22:0] off;
                        off = (o == 0) ? 23'h0 : (o == 1) ? 23'h1 : (o == 2) ? 23'h7FFFFF :
                              (o == 3) ? 23'h123457 : (o == 4) ? 23'h400000 : 23'h2AAAA4;
                        acc(2, k[0], k[1], {s[1:0], off}, 16'hBEEF ^ 16'(o));
                        acc(3, k[0], k[1], {1'b0, s[1:0], off[21:0]}, 16'hC0DE ^ 16'(o));
                    end
        end

        done = 1;
        finish_run();
    end
endmodule